// File: doc/BRIEF.md
# Read-Strobe Delay Code Generator with Master Lock Search

This block produces the delay-element counts for the read data-strobe delay lines of several byte lanes in a DDR interface. In normal operation it first finds how many chain elements make up one clock period. It starts a master count at a programmed value and waits a programmed number of settle cycles. It then samples a lock indication from an external phase detector. If there is no lock, it adds a programmed increment and tries again. Once the master count is locked, each lane's fractional setting (in 1/128ths of a clock period) is scaled by the locked count to give that lane's element count.

A single mode input selects bypass operation instead. In bypass mode the search never runs, and each lane takes its raw element-count setting directly. In both modes every lane code is clamped to the number of elements the chain actually has. If the search would step past the end of the chain, the block flags a lock failure and parks the master count at the chain length. The analog chain and the phase detector sit outside this block; they appear only as ports.

Top module: `dqs_delay_calc`

## Requirements
- R1: While reset is asserted and on the first edge after it, `master_count`, every lane code, `dll_locked` and `lock_fail` read zero.
- R2: In normal mode (`bypass_sel`=0), the first clock edge after reset loads `master_count` with `start_point`, provided `start_point` does not exceed CHAIN_MAX.
- R3: After a step, the search waits `settle_cycles` further edges, then samples `phase_lock` on the next edge. If the sample is low, the following edge raises `master_count` by `step_incr`.
- R4: `phase_lock` has no effect except on the single sampling edge at the end of each settle window. A step with `settle_cycles`=S and `phase_lock` held high locks exactly S+1 edges after the count was loaded.
- R5: When a sample sees `phase_lock` high, `dll_locked` goes to 1 and stays there, with `master_count` frozen.
- R6: In normal mode each lane code holds its value while `dll_locked` is 0. One edge after each locked cycle, it becomes min((master_count × setting) >> 7, CHAIN_MAX), where setting is the lane's 7-bit field at bits [7i+6:7i] of `frac_delay`.
- R7: In bypass mode the search is skipped and `master_count` and `dll_locked` stay 0. From the first edge after reset, lane i shows min(raw, CHAIN_MAX), where raw is bits [10i+9:10i] of `raw_delay`.
- R8: If `start_point` exceeds CHAIN_MAX, or a step would exceed it, then `lock_fail` goes to 1 and stays there, `master_count` becomes CHAIN_MAX, `dll_locked` stays 0 and the normal-mode lane codes hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_sel | input | 1 | 0 selects normal (scaled) mode, 1 selects bypass (raw count) mode |
| start_point | input | 10 | Master count at which the search begins |
| step_incr | input | 10 | Amount added to the master count on each failed sample |
| settle_cycles | input | 4 | Extra cycles waited after each step before sampling |
| phase_lock | input | 1 | Lock indication from the phase detector |
| frac_delay | input | 28 | Four 7-bit fractional lane settings, lane 0 in the low bits |
| raw_delay | input | 40 | Four 10-bit raw element counts, lane 0 in the low bits |
| master_count | output | 10 | Current master element count |
| dll_locked | output | 1 | Search has locked |
| lock_fail | output | 1 | Search ran past the chain end |
| lane_delay | output | 40 | Four 10-bit lane element codes, lane 0 in the low bits |

## Verification
The assertions assume that `bypass_sel` only changes while reset is asserted and that the configuration inputs are static during a search. The bench therefore reprograms the mode, start point, increment and settle length only while reset is asserted. It drives `phase_lock` either from a count threshold that acts like a real phase detector, or as a pseudo-random bit that is often high inside settle windows. Because the lane settings are only read at outputs that are proven by comparison every cycle, they may change at any time.

// File: rtl/dqs_delay_pkg.sv
package dqs_delay_pkg;

    typedef enum logic [2:0] {
        SRCH_IDLE,
        SRCH_STEP,
        SRCH_SETTLE,
        SRCH_LOCKED,
        SRCH_FAILED
    } srch_state_e;

endpackage

// File: rtl/dqs_lock_search.sv
module dqs_lock_search
    import dqs_delay_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int SET_W     = 4,
    parameter int CHAIN_MAX = 800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass_sel,
    input  logic [CNT_W-1:0] start_point,
    input  logic [CNT_W-1:0] step_incr,
    input  logic [SET_W-1:0] settle_cycles,
    input  logic             phase_lock,
    output logic [CNT_W-1:0] count_o,
    output srch_state_e      state_o
);

    localparam logic [CNT_W:0]   LIMIT_W = (CNT_W+1)'(CHAIN_MAX);
    localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(CHAIN_MAX);

    typedef struct packed {
        srch_state_e      state;
        logic [CNT_W-1:0] count;
        logic [SET_W-1:0] wait_left;
    } srch_regs_t;

    srch_regs_t r_d, r_q;
    logic [CNT_W:0] stepped;

    always_comb begin
        r_d     = r_q;
        stepped = {1'b0, r_q.count} + {1'b0, step_incr};
        unique case (r_q.state)
            SRCH_IDLE: begin
                if (!bypass_sel) begin
                    if ({1'b0, start_point} > LIMIT_W) begin
                        r_d.count = LIMIT;
                        r_d.state = SRCH_FAILED;
                    end else begin
                        r_d.count     = start_point;
                        r_d.wait_left = settle_cycles;
                        r_d.state     = SRCH_SETTLE;
                    end
                end
            end
            SRCH_STEP: begin
                if (stepped > LIMIT_W) begin
                    r_d.count = LIMIT;
                    r_d.state = SRCH_FAILED;
                end else begin
                    r_d.count     = stepped[CNT_W-1:0];
                    r_d.wait_left = settle_cycles;
                    r_d.state     = SRCH_SETTLE;
                end
            end
            SRCH_SETTLE: begin
                if (r_q.wait_left != '0) begin
                    r_d.wait_left = r_q.wait_left - 1'b1;
                end else if (phase_lock) begin
                    r_d.state = SRCH_LOCKED;
                end else begin
                    r_d.state = SRCH_STEP;
                end
            end
            SRCH_LOCKED: r_d = r_q;
            SRCH_FAILED: r_d = r_q;
            default:     r_d.state = SRCH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= SRCH_IDLE;
            r_q.count     <= '0;
            r_q.wait_left <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign count_o = r_q.count;
    assign state_o = r_q.state;

endmodule

// File: rtl/dqs_lane_scale.sv
module dqs_lane_scale #(
    parameter int CNT_W     = 10,
    parameter int FRAC_W    = 7,
    parameter int CHAIN_MAX = 800
) (
    input  logic              bypass_sel,
    input  logic [CNT_W-1:0]  master_cnt,
    input  logic [FRAC_W-1:0] frac_set,
    input  logic [CNT_W-1:0]  raw_set,
    output logic [CNT_W-1:0]  code_o
);

    localparam int          PROD_W = CNT_W + FRAC_W;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CHAIN_MAX);

    logic [PROD_W-1:0] prod;
    logic [CNT_W-1:0]  scaled;
    logic [CNT_W-1:0]  pick;

    always_comb begin
        prod   = {{FRAC_W{1'b0}}, master_cnt} * {{CNT_W{1'b0}}, frac_set};
        scaled = prod[PROD_W-1:FRAC_W];
        pick   = bypass_sel ? raw_set : scaled;
        code_o = (pick > LIMIT) ? LIMIT : pick;
    end

endmodule

// File: rtl/dqs_delay_calc.sv
module dqs_delay_calc
    import dqs_delay_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int CNT_W     = 10,
    parameter int FRAC_W    = 7,
    parameter int SET_W     = 4,
    parameter int CHAIN_MAX = 800
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bypass_sel,
    input  logic [CNT_W-1:0]        start_point,
    input  logic [CNT_W-1:0]        step_incr,
    input  logic [SET_W-1:0]        settle_cycles,
    input  logic                    phase_lock,
    input  logic [LANES*FRAC_W-1:0] frac_delay,
    input  logic [LANES*CNT_W-1:0]  raw_delay,
    output logic [CNT_W-1:0]        master_count,
    output logic                    dll_locked,
    output logic                    lock_fail,
    output logic [LANES*CNT_W-1:0]  lane_delay
);

    srch_state_e      srch_state;
    logic [CNT_W-1:0] srch_count;
    logic [CNT_W-1:0] lane_next [LANES];
    logic [CNT_W-1:0] lane_d    [LANES];
    logic [CNT_W-1:0] lane_q    [LANES];
    logic             lane_upd;

    dqs_lock_search #(
        .CNT_W    (CNT_W),
        .SET_W    (SET_W),
        .CHAIN_MAX(CHAIN_MAX)
    ) search_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bypass_sel   (bypass_sel),
        .start_point  (start_point),
        .step_incr    (step_incr),
        .settle_cycles(settle_cycles),
        .phase_lock   (phase_lock),
        .count_o      (srch_count),
        .state_o      (srch_state)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        dqs_lane_scale #(
            .CNT_W    (CNT_W),
            .FRAC_W   (FRAC_W),
            .CHAIN_MAX(CHAIN_MAX)
        ) scale_i (
            .bypass_sel(bypass_sel),
            .master_cnt(srch_count),
            .frac_set  (frac_delay[i*FRAC_W +: FRAC_W]),
            .raw_set   (raw_delay[i*CNT_W +: CNT_W]),
            .code_o    (lane_next[i])
        );
        assign lane_delay[i*CNT_W +: CNT_W] = lane_q[i];
    end

    always_comb begin
        lane_upd = bypass_sel || (srch_state == SRCH_LOCKED);
        for (int i = 0; i < LANES; i++) begin
            lane_d[i] = lane_upd ? lane_next[i] : lane_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) lane_q[i] <= lane_d[i];
        end
    end

    assign master_count = srch_count;
    assign dll_locked   = (srch_state == SRCH_LOCKED);
    assign lock_fail    = (srch_state == SRCH_FAILED);

endmodule

// File: rtl/dqs_delay_calc_chk.sv
module dqs_delay_calc_chk #(
    parameter int LANES     = 4,
    parameter int CNT_W     = 10,
    parameter int CHAIN_MAX = 800
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bypass_sel,
    input logic [CNT_W-1:0]       master_count,
    input logic                   dll_locked,
    input logic                   lock_fail,
    input logic [LANES*CNT_W-1:0] lane_delay
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CHAIN_MAX);

    // R8: the two terminal indications never coexist
    assert_lock_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dll_locked && lock_fail))
        else $error("lock and fail together");

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        master_count <= LIMIT)
        else $error("master count past chain end");

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_fail |=> lock_fail && master_count == LIMIT)
        else $error("fail not sticky");

    assert_lock_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dll_locked |=> dll_locked && $stable(master_count))
        else $error("locked count moved");

    assert_lane_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_sel && !dll_locked) |=> $stable(lane_delay))
        else $error("lane changed while unlocked");

    assert_no_search_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_sel |-> (!dll_locked && !lock_fail && master_count == '0))
        else $error("search ran in bypass");

    for (genvar i = 0; i < LANES; i++) begin : g_bound
        assert_lane_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lane_delay[i*CNT_W +: CNT_W] <= LIMIT)
            else $error("lane code past chain end");
    end

endmodule

bind dqs_delay_calc dqs_delay_calc_chk #(
    .LANES    (LANES),
    .CNT_W    (CNT_W),
    .CHAIN_MAX(CHAIN_MAX)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bypass_sel  (bypass_sel),
    .master_count(master_count),
    .dll_locked  (dll_locked),
    .lock_fail   (lock_fail),
    .lane_delay  (lane_delay)
);

// File: tb/dqs_delay_calc_tb_top.sv
`timescale 1ns/1ps
module dqs_delay_calc_tb_top;

    localparam int LANES = 4;
    localparam int CW    = 10;
    localparam int FW    = 7;
    localparam int MAXC  = 800;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bypass_sel = 1'b0;
    logic [CW-1:0]    start_point = '0;
    logic [CW-1:0]    step_incr = '0;
    logic [3:0]       settle_cycles = '0;
    logic             phase_lock = 1'b0;
    logic [LANES*FW-1:0] frac_delay = '0;
    logic [LANES*CW-1:0] raw_delay = '0;
    logic [CW-1:0]    master_count;
    logic             dll_locked;
    logic             lock_fail;
    logic [LANES*CW-1:0] lane_delay;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dqs_delay_calc dut_i (
        .clk(clk), .rst_n(rst_n), .bypass_sel(bypass_sel),
        .start_point(start_point), .step_incr(step_incr),
        .settle_cycles(settle_cycles), .phase_lock(phase_lock),
        .frac_delay(frac_delay), .raw_delay(raw_delay),
        .master_count(master_count), .dll_locked(dll_locked),
        .lock_fail(lock_fail), .lane_delay(lane_delay)
    );

    // behavioural reference: phase 0 idle, 1 stepping, 2 settling, 3 locked, 4 failed
    int m_phase, m_cnt, m_wait;
    int m_lane [LANES];

    function automatic int clampc(int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_wait = 0;
            for (int i = 0; i < LANES; i++) m_lane[i] = 0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (bypass_sel)
                    m_lane[i] = clampc(int'(raw_delay[i*CW +: CW]));
                else if (m_phase == 3)
                    m_lane[i] = clampc((m_cnt * int'(frac_delay[i*FW +: FW])) / 128);
            end
            case (m_phase)
                0: if (!bypass_sel) begin
                    if (int'(start_point) > MAXC) begin m_cnt = MAXC; m_phase = 4; end
                    else begin m_cnt = int'(start_point); m_wait = int'(settle_cycles); m_phase = 2; end
                end
                1: if (m_cnt + int'(step_incr) > MAXC) begin m_cnt = MAXC; m_phase = 4; end
                   else begin m_cnt = m_cnt + int'(step_incr); m_wait = int'(settle_cycles); m_phase = 2; end
                2: if (m_wait != 0) m_wait = m_wait - 1;
                   else m_phase = phase_lock ? 3 : 1;
                default: ;
            endcase
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R3 master_count vs model", int'(master_count), m_cnt);
            chk("R5 dll_locked vs model", int'(dll_locked), int'(m_phase == 3));
            chk("R8 lock_fail vs model", int'(lock_fail), int'(m_phase == 4));
            for (int i = 0; i < LANES; i++)
                chk(bypass_sel ? "R7 lane vs model" : "R6 lane vs model",
                    int'(lane_delay[i*CW +: CW]), m_lane[i]);
        end
    end

    task automatic do_reset(bit byp, int sp, int inc, int st);
        @(negedge clk);
        rst_n = 1'b0; phase_lock = 1'b0;
        bypass_sel = byp; start_point = CW'(sp); step_incr = CW'(inc);
        settle_cycles = 4'(st);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int lane(int i);
        return int'(lane_delay[i*CW +: CW]);
    endfunction

    initial begin
        frac_delay = {7'd1, 7'd0, 7'd127, 7'd64};
        raw_delay  = {10'd1023, 10'd801, 10'd800, 10'd5};
        // R1: reset state
        do_reset(1'b0, 100, 50, 2);
        rst_n = 1'b0;
        #1;
        chk("R1 count in reset", int'(master_count), 0);
        chk("R1 locked in reset", int'(dll_locked), 0);
        chk("R1 fail in reset", int'(lock_fail), 0);
        chk("R1 lanes in reset", int'(lane_delay), 0);
        cmp_on = 1'b1;

        // R2 R3 R5 R6: lock found at count 250 by a threshold detector
        do_reset(1'b0, 100, 50, 2);
        @(negedge clk);
        chk("R2 start loaded", int'(master_count), 100);
        for (int c = 0; c < 60; c++) begin
            phase_lock = (master_count >= 250);
            @(negedge clk);
        end
        chk("R5 locked", int'(dll_locked), 1);
        chk("R3 locked count", int'(master_count), 250);
        chk("R6 lane0 64/128", lane(0), 125);
        chk("R6 lane1 127/128", lane(1), 248);
        chk("R6 lane2 zero", lane(2), 0);
        chk("R6 lane3 1/128", lane(3), 1);

        // R4: constant lock, settle 3 -> locks 4 edges after load
        do_reset(1'b0, 300, 10, 3);
        phase_lock = 1'b1;
        @(negedge clk);
        chk("R2 start loaded", int'(master_count), 300);
        repeat (3) @(negedge clk);
        chk("R4 not yet locked", int'(dll_locked), 0);
        chk("R6 lane held before lock", lane(0), 0);
        @(negedge clk);
        chk("R4 locked after settle", int'(dll_locked), 1);
        @(negedge clk);
        chk("R6 lane after lock", lane(0), 150);

        // R8: search walks past the chain end
        do_reset(1'b0, 700, 64, 1);
        repeat (20) @(negedge clk);
        chk("R8 fail flag", int'(lock_fail), 1);
        chk("R8 count parked", int'(master_count), MAXC);
        chk("R8 lanes held", int'(lane_delay), 0);

        // R8: start beyond the chain end
        do_reset(1'b0, 900, 5, 0);
        @(negedge clk);
        chk("R8 start too big fail", int'(lock_fail), 1);
        chk("R8 start too big count", int'(master_count), MAXC);

        // R7: bypass, raw codes with clamp
        do_reset(1'b1, 100, 50, 2);
        @(negedge clk);
        chk("R7 lane0 raw", lane(0), 5);
        chk("R7 lane1 at max", lane(1), 800);
        chk("R7 lane2 clamped", lane(2), 800);
        chk("R7 lane3 clamped", lane(3), 800);
        chk("R7 no lock", int'(dll_locked), 0);
        chk("R7 count idle", int'(master_count), 0);
        repeat (5) @(negedge clk);
        chk("R7 still no search", int'(master_count), 0);

        // R4 R3: noisy detector, only sampling edges matter (model compare)
        for (int run = 0; run < 6; run++) begin
            do_reset(1'b0, 20 + run * 7, 9 + run, run % 5);
            for (int c = 0; c < 400; c++) begin
                phase_lock = ($urandom % 7) == 0;
                if (c % 37 == 0) frac_delay = LANES*FW'($urandom);
                @(negedge clk);
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule